// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the sync, blank and strobe signals a raster display needs, one pixel per clock. It runs on the pixel clock. Each axis is described by four numbers: a sync width, a gate delay after sync, a visible gate width and a total span length. Every one of them is programmed as the wanted count minus one. A line starts with sync, then the gate delay, then the visible gate, and then blanking fills the line up to its total length. The vertical axis follows the same order, counted in lines.

The timing inputs are static words. They are sampled only when a frame begins, so software or a fetch engine can rewrite them at any time without tearing the frame on screen. The fetch path gets a pixel-valid strobe and one-clock line-start and frame-start pulses. Four separate polarity inputs can invert hsync, vsync, composite sync and blank one at a time. While the enable input is low, the outputs sit in their idle state and the position counters stay cleared.

Top module: `vid_timing_gen`

## Requirements
- R1: `h_timing` and `v_timing` each hold the sync value in bits [31:24], the gate-delay value in [23:16] and the gate value in [15:0]. `span_lengths` holds the horizontal total in [31:16] and the vertical total in [15:0].
- R2: A line lasts htotal+1 clocks and a frame lasts vtotal+1 lines. Outputs are registered, so position 0 of a frame appears on the second rising edge after enable is first sampled high. `line_start` is high at horizontal position 0. `frame_start` is high only at horizontal and vertical position 0, and only together with `line_start`.
- R3: hsync is active for horizontal positions 0 to hsync value. vsync is active for lines 0 to vsync value.
- R4: The gate of an axis covers positions sync+gdel+2 through sync+gdel+2+gate. Positions past the axis total cut it short. `pix_valid` is high when both gates are active, and blank is asserted exactly when `pix_valid` is low.
- R5: Composite sync is the XOR of active-high hsync and vsync, taken before any polarity is applied.
- R6: Each polarity input (`pol_hsync`, `pol_vsync`, `pol_csync`, `pol_blank`), when 1, inverts only its own output. It acts in the cycle it is presented.
- R7: Sync and gate-delay values of zero give one-clock (or one-line) phases, and the timing stays correct.
- R8: The timing words are sampled only at frame start. A change in the middle of a frame has no effect until the next frame.
- R9: On the first edge that samples `video_en` low, the outputs become idle: syncs inactive, blank asserted, and pix_valid and both strobes low. Enabling again restarts at position 0 of a frame.
- R10: During reset, `hsync_o`, `vsync_o`, `csync_o`, `pix_valid`, `line_start` and `frame_start` are 0 and `blank_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Run enable |
| h_timing | input | 32 | Horizontal sync, gate delay and gate, each minus one |
| v_timing | input | 32 | Vertical sync, gate delay and gate, each minus one |
| span_lengths | input | 32 | Horizontal and vertical totals, each minus one |
| pol_hsync | input | 1 | Invert hsync |
| pol_vsync | input | 1 | Invert vsync |
| pol_csync | input | 1 | Invert composite sync |
| pol_blank | input | 1 | Invert blank |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blank |
| pix_valid | output | 1 | Visible pixel strobe |
| line_start | output | 1 | First clock of each line |
| frame_start | output | 1 | First clock of each frame |

## Verification
The hardest case to reach from the ports is a timing rewrite in the middle of a frame. The frame in progress must keep its old geometry, and the new geometry must take effect exactly at the wrap. The bench starts a frame with one set of words and swaps in a set with different totals a few clocks later. It then checks every position of the rest of that frame against the old set and every position of the following frame against the new set. A horizontal gate that runs past the line total is also hard to reach. A table row is built to truncate the gate, and another row uses all-zero sync and delay values.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   localparam int unsigned POL_COUNT = 4;

   typedef struct packed {
      logic hsync;
      logic vsync;
      logic csync;
      logic blank;
      logic pix_valid;
      logic line_start;
      logic frame_start;
   } vtg_flags_t;

   localparam vtg_flags_t FLAGS_IDLE = '{hsync: 1'b0, vsync: 1'b0, csync: 1'b0,
                                          blank: 1'b1, pix_valid: 1'b0,
                                          line_start: 1'b0, frame_start: 1'b0};

endpackage

// File: rtl/vtg_cfg_latch.sv
module vtg_cfg_latch #(
   parameter int SYNC_W = 8,
   parameter int SPAN_W = 16,
   localparam int WORD_W = 2*SYNC_W + SPAN_W,
   localparam int LEN_W  = 2*SPAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] tim_h,
   input  logic [WORD_W-1:0] tim_v,
   input  logic [LEN_W-1:0]  lens,
   output logic [SYNC_W-1:0] sync_q  [2],
   output logic [SYNC_W-1:0] gdel_q  [2],
   output logic [SPAN_W-1:0] gate_q  [2],
   output logic [SPAN_W-1:0] total_q [2]
);
   // axis 0 = horizontal, axis 1 = vertical
   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [WORD_W-1:0] word;
      logic [SPAN_W-1:0] tot;
      assign word = (a == 0) ? tim_h : tim_v;
      assign tot  = (a == 0) ? lens[LEN_W-1:SPAN_W] : lens[SPAN_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[a]  <= '0;
            gdel_q[a]  <= '0;
            gate_q[a]  <= '0;
            total_q[a] <= '0;
         end else if (load) begin
            sync_q[a]  <= word[WORD_W-1 -: SYNC_W];
            gdel_q[a]  <= word[SPAN_W+SYNC_W-1 -: SYNC_W];
            gate_q[a]  <= word[SPAN_W-1:0];
            total_q[a] <= tot;
         end
      end
   end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
   parameter int SYNC_W = 8,
   parameter int SPAN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [SYNC_W-1:0] sync_len,
   input  logic [SYNC_W-1:0] gdel_len,
   input  logic [SPAN_W-1:0] gate_len,
   input  logic [SPAN_W-1:0] total_len,
   output logic [SPAN_W-1:0] pos,
   output logic              wrap,
   output logic              sync_act,
   output logic              gate_act
);
   localparam int EXT_W = SPAN_W + 2;

   logic [EXT_W-1:0] gate_first;
   logic [EXT_W-1:0] gate_last;
   logic [EXT_W-1:0] pos_ext;
   logic             at_end;

   assign at_end = (pos == total_len);
   assign wrap   = step && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pos <= '0;
      else if (clear)     pos <= '0;
      else if (step)      pos <= at_end ? '0 : pos + 1'b1;
   end

   assign pos_ext    = EXT_W'(pos);
   assign gate_first = EXT_W'(sync_len) + EXT_W'(gdel_len) + EXT_W'(2);
   assign gate_last  = gate_first + EXT_W'(gate_len);
   assign sync_act   = (pos_ext <= EXT_W'(sync_len));
   assign gate_act   = (pos_ext >= gate_first) && (pos_ext <= gate_last);
endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
   import vtg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  vtg_flags_t           raw,
   input  logic [POL_COUNT-1:0] pol,
   output vtg_flags_t           q
);
   logic [POL_COUNT-1:0] pol_src;
   logic [POL_COUNT-1:0] pol_q;
   localparam logic [POL_COUNT-1:0] POL_RST = {FLAGS_IDLE.blank, FLAGS_IDLE.csync,
                                               FLAGS_IDLE.vsync, FLAGS_IDLE.hsync};

   assign pol_src = {raw.blank, raw.csync, raw.vsync, raw.hsync};

   for (genvar i = 0; i < POL_COUNT; i++) begin : g_pol
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pol_q[i] <= POL_RST[i];
         else        pol_q[i] <= pol_src[i] ^ pol[i];
      end
   end

   logic pv_q, ls_q, fs_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q <= FLAGS_IDLE.pix_valid;
         ls_q <= FLAGS_IDLE.line_start;
         fs_q <= FLAGS_IDLE.frame_start;
      end else begin
         pv_q <= raw.pix_valid;
         ls_q <= raw.line_start;
         fs_q <= raw.frame_start;
      end
   end

   assign q = '{hsync: pol_q[0], vsync: pol_q[1], csync: pol_q[2], blank: pol_q[3],
                pix_valid: pv_q, line_start: ls_q, frame_start: fs_q};
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int SYNC_W = 8,
   parameter int SPAN_W = 16,
   localparam int WORD_W = 2*SYNC_W + SPAN_W,
   localparam int LEN_W  = 2*SPAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              video_en,
   input  logic [WORD_W-1:0] h_timing,
   input  logic [WORD_W-1:0] v_timing,
   input  logic [LEN_W-1:0]  span_lengths,
   input  logic              pol_hsync,
   input  logic              pol_vsync,
   input  logic              pol_csync,
   input  logic              pol_blank,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              csync_o,
   output logic              blank_o,
   output logic              pix_valid,
   output logic              line_start,
   output logic              frame_start
);
   if (SYNC_W < 1) begin : g_bad_sync
      $error("vid_timing_gen: SYNC_W must be at least 1");
   end
   if (SPAN_W < SYNC_W) begin : g_bad_span
      $error("vid_timing_gen: SPAN_W must not be narrower than SYNC_W");
   end

   logic [SYNC_W-1:0] sync_q  [2];
   logic [SYNC_W-1:0] gdel_q  [2];
   logic [SPAN_W-1:0] gate_q  [2];
   logic [SPAN_W-1:0] total_q [2];

   logic running;
   logic active;
   logic frame_end;
   logic cfg_load;
   logic [SPAN_W-1:0] pos   [2];
   logic [1:0]        wrap;
   logic [1:0]        sync_act;
   logic [1:0]        gate_act;
   logic [1:0]        step;

   assign active    = running && video_en;
   assign frame_end = wrap[0] && wrap[1];
   assign cfg_load  = video_en && (!running || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) running <= 1'b0;
      else        running <= video_en;
   end

   vtg_cfg_latch #(.SYNC_W(SYNC_W), .SPAN_W(SPAN_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load),
      .tim_h(h_timing), .tim_v(v_timing), .lens(span_lengths),
      .sync_q(sync_q), .gdel_q(gdel_q), .gate_q(gate_q), .total_q(total_q)
   );

   assign step[0] = active;
   assign step[1] = wrap[0];

   for (genvar a = 0; a < 2; a++) begin : g_axis
      vtg_axis #(.SYNC_W(SYNC_W), .SPAN_W(SPAN_W)) u_axis (
         .clk(clk), .rst_n(rst_n), .clear(!active), .step(step[a]),
         .sync_len(sync_q[a]), .gdel_len(gdel_q[a]),
         .gate_len(gate_q[a]), .total_len(total_q[a]),
         .pos(pos[a]), .wrap(wrap[a]),
         .sync_act(sync_act[a]), .gate_act(gate_act[a])
      );
   end

   vtg_flags_t raw;
   vtg_flags_t outq;
   logic hs_a, vs_a, pv_a, ls_a;

   assign hs_a = active && sync_act[0];
   assign vs_a = active && sync_act[1];
   assign pv_a = active && gate_act[0] && gate_act[1];
   assign ls_a = active && (pos[0] == '0);

   assign raw = '{hsync: hs_a, vsync: vs_a, csync: hs_a ^ vs_a, blank: !pv_a,
                  pix_valid: pv_a, line_start: ls_a,
                  frame_start: ls_a && (pos[1] == '0)};

   vtg_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .raw(raw),
      .pol({pol_blank, pol_csync, pol_vsync, pol_hsync}),
      .q(outq)
   );

   assign hsync_o     = outq.hsync;
   assign vsync_o     = outq.vsync;
   assign csync_o     = outq.csync;
   assign blank_o     = outq.blank;
   assign pix_valid   = outq.pix_valid;
   assign line_start  = outq.line_start;
   assign frame_start = outq.frame_start;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker (
   input logic clk,
   input logic rst_n,
   input logic video_en,
   input logic pol_hsync,
   input logic pol_vsync,
   input logic pol_csync,
   input logic pol_blank,
   input logic hsync_o,
   input logic vsync_o,
   input logic csync_o,
   input logic blank_o,
   input logic pix_valid,
   input logic line_start,
   input logic frame_start
);
   logic [1:0] since_ls;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_ls <= 2'd0;
      else if (line_start)      since_ls <= 2'd1;
      else if (since_ls != 2'd3 && since_ls != 2'd0) since_ls <= since_ls + 2'd1;
   end

   assert_frame_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);

   assert_gate_after_line_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (!line_start && since_ls >= 2'd2));

   assert_csync_xor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((csync_o ^ $past(pol_csync)) ==
                        ((hsync_o ^ $past(pol_hsync)) ^ (vsync_o ^ $past(pol_vsync)))));

   assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(video_en)) |->
         (!pix_valid && !line_start && !frame_start &&
          hsync_o == $past(pol_hsync) && vsync_o == $past(pol_vsync) &&
          blank_o == !$past(pol_blank)));
endmodule

bind vid_timing_gen vtg_checker u_chk (
   .clk(clk), .rst_n(rst_n), .video_en(video_en),
   .pol_hsync(pol_hsync), .pol_vsync(pol_vsync),
   .pol_csync(pol_csync), .pol_blank(pol_blank),
   .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o),
   .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start)
);

// File: tb/sim_vid_timing_gen.sv
module sim_vid_timing_gen;
   typedef struct packed {
      logic [7:0]  hs;
      logic [7:0]  hd;
      logic [15:0] hg;
      logic [15:0] hl;
      logic [7:0]  vs;
      logic [7:0]  vd;
      logic [15:0] vg;
      logic [15:0] vl;
      logic [3:0]  pol;   // {blank, csync, vsync, hsync}
   } cfg_t;

   // row 0: zero sync/delay (R7); row 2: gate cut short by line end (R4)
   localparam cfg_t TABLE [5] = '{
      '{8'd0, 8'd0, 16'd9,  16'd12, 8'd0, 8'd0, 16'd3, 16'd5, 4'b0000},
      '{8'd2, 8'd1, 16'd7,  16'd15, 8'd1, 8'd0, 16'd2, 16'd6, 4'b0001},
      '{8'd1, 8'd1, 16'd10, 16'd13, 8'd1, 8'd1, 16'd4, 16'd7, 4'b0010},
      '{8'd3, 8'd2, 16'd5,  16'd14, 8'd0, 8'd1, 16'd2, 16'd5, 4'b1100},
      '{8'd1, 8'd0, 16'd4,  16'd9,  8'd2, 8'd0, 16'd1, 16'd6, 4'b1111}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic video_en = 1'b0;
   logic [31:0] h_timing = '0, v_timing = '0, span_lengths = '0;
   logic pol_hsync = 1'b0, pol_vsync = 1'b0, pol_csync = 1'b0, pol_blank = 1'b0;
   logic hsync_o, vsync_o, csync_o, blank_o, pix_valid, line_start, frame_start;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vid_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .video_en(video_en),
      .h_timing(h_timing), .v_timing(v_timing), .span_lengths(span_lengths),
      .pol_hsync(pol_hsync), .pol_vsync(pol_vsync),
      .pol_csync(pol_csync), .pol_blank(pol_blank),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o),
      .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start)
   );

   task automatic check1(string req, string what, logic act, logic exp, string ctx);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0b expected=%0b %s", req, what, act, exp, ctx);
      end
   endtask

   // R1: field packing of the three timing words
   task automatic apply(cfg_t c);
      h_timing     = {c.hs, c.hd, c.hg};
      v_timing     = {c.vs, c.vd, c.vg};
      span_lengths = {c.hl, c.vl};
      {pol_blank, pol_csync, pol_vsync, pol_hsync} = c.pol;
   endtask

   task automatic check_pos(cfg_t c, int h, int v);
      int hgs, vgs;
      bit hsa, vsa, pv;
      string ctx;
      hgs = int'(c.hs) + int'(c.hd) + 2;
      vgs = int'(c.vs) + int'(c.vd) + 2;
      hsa = (h <= int'(c.hs));
      vsa = (v <= int'(c.vs));
      pv  = (h >= hgs) && (h <= hgs + int'(c.hg)) && (v >= vgs) && (v <= vgs + int'(c.vg));
      ctx = $sformatf("(h=%0d v=%0d)", h, v);
      check1("R3/R6", "hsync", hsync_o, hsa ^ c.pol[0], ctx);
      check1("R3/R6", "vsync", vsync_o, vsa ^ c.pol[1], ctx);
      check1("R5/R6", "csync", csync_o, (hsa ^ vsa) ^ c.pol[2], ctx);
      check1("R4/R6", "blank", blank_o, !pv ^ c.pol[3], ctx);
      check1("R4", "pix_valid", pix_valid, pv, ctx);
      check1("R2", "line_start", line_start, h == 0, ctx);
      check1("R2", "frame_start", frame_start, (h == 0) && (v == 0), ctx);
   endtask

   task automatic check_idle(string req);
      check1(req, "hsync idle", hsync_o, pol_hsync, "");
      check1(req, "vsync idle", vsync_o, pol_vsync, "");
      check1(req, "csync idle", csync_o, pol_csync, "");
      check1(req, "blank idle", blank_o, !pol_blank, "");
      check1(req, "pix_valid idle", pix_valid, 1'b0, "");
      check1(req, "line_start idle", line_start, 1'b0, "");
      check1(req, "frame_start idle", frame_start, 1'b0, "");
   endtask

   // Frame with a, inputs switch to b after position change_at, then one frame of b
   // plus its wrap back to position 0 (R8).
   task automatic run(cfg_t a, cfg_t b, int change_at);
      int la, lb;
      apply(a);
      la = (int'(a.hl) + 1) * (int'(a.vl) + 1);
      lb = (int'(b.hl) + 1) * (int'(b.vl) + 1);
      @(negedge clk);
      video_en = 1'b1;
      @(posedge clk);
      for (int k = 0; k < la; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == change_at) apply(b);
         if (k >= change_at && change_at >= 0) begin
            {pol_blank, pol_csync, pol_vsync, pol_hsync} = a.pol;
         end
         check_pos(a, k % (int'(a.hl) + 1), k / (int'(a.hl) + 1));
      end
      {pol_blank, pol_csync, pol_vsync, pol_hsync} = b.pol;
      for (int k = 0; k <= lb; k++) begin
         @(posedge clk);
         @(negedge clk);
         check_pos(b, k % (int'(b.hl) + 1), (k / (int'(b.hl) + 1)) % (int'(b.vl) + 1));
      end
   endtask

   task automatic stop_video(string req);
      @(negedge clk);
      video_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_idle(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      // R10: reset state with all polarity inputs set
      apply(TABLE[4]);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check1("R10", "hsync reset", hsync_o, 1'b0, "");
      check1("R10", "vsync reset", vsync_o, 1'b0, "");
      check1("R10", "csync reset", csync_o, 1'b0, "");
      check1("R10", "blank reset", blank_o, 1'b1, "");
      check1("R10", "pix_valid reset", pix_valid, 1'b0, "");
      check1("R10", "line_start reset", line_start, 1'b0, "");
      check1("R10", "frame_start reset", frame_start, 1'b0, "");
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_idle("R9");

      // Table walk: every row for two frames and a wrap (R1..R7)
      for (int i = 0; i < 5; i++) begin
         run(TABLE[i], TABLE[i], -1);
         stop_video("R9");
      end

      // R8: rewrite the words five clocks into a frame
      run(TABLE[1], TABLE[3], 5);
      stop_video("R9");
      run(TABLE[3], TABLE[0], 40);
      stop_video("R9");

      // R9: stop in mid-frame, stay idle, restart from frame start
      apply(TABLE[2]);
      @(negedge clk);
      video_en = 1'b1;
      repeat (9) @(posedge clk);
      stop_video("R9");
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R9");
      run(TABLE[2], TABLE[2], -1);
      stop_video("R9");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule